// File: doc/BRIEF.md
# PLL Bring-up and Clock Source Switch Sequencer

This block is a small bus master that brings two phase-locked loops online after boot and moves the clock mux of each onto its PLL. A single start pulse launches a fixed program. For each PLL it clears and then programs the loop configuration words, writes the requested multiplier and releases bypass. After a timed pause it releases reset, selects run mode and polls the lock flag within a bounded window. Once the loop is locked it enables the PLL output and switches the mux source field with a read-modify-write.

The block serves the CPU cluster PLL first and then the cache PLL. Each has its own register bank base, so a timeout on one PLL does not stop the other. Delays are measured in whole pulses of a one-microsecond tick input. The result is one error flag per PLL and a level `done` once both PLLs have been attempted.

Top module: `pll_boot_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_req` and both `pll_err` bits are 0.
- R2: Per PLL the bus writes, as byte offsets from the bank base, are exactly:
  - 0x10 = 0, then 0x10 = 0x20000AA8;
  - 0x14 = 0, then 0x14 = 0x3D2;
  - 0x18 = 0;
  - 0x04 = L value;
  - mode 0x00 with bit 1 set, then 0x00 with bit 2 set;
  - 0x28 with bit 0 set;
  - after lock, 0x00 with bit 0 set, then the mux word 0x88.
- R3: Every bit-set step reads the register first and writes back the read value OR the new bits, so that unrelated bits survive. The only exception is the mux step (R6).
- R4: At least 5 tick pulses pass between the mode write that sets bit 1 and the mode write that sets bit 2.
- R5: Mode bit 31 is the lock flag. The block reads mode repeatedly until bit 31 reads 1, and only then performs the output enable and mux writes.
- R6: The mux write takes the read value, clears bits [1:0], places 2 in them and keeps all other bits.
- R7: If bit 31 has not read 1 once 100 tick pulses have passed since polling began, the block sets that PLL's error flag and skips the output enable and mux writes. It starts the next PLL no more than 102 ticks after the run-mode write.
- R8: The CPU PLL (bank base `BASE_CPU`, multiplier `lval_cpu`) is processed first and the cache PLL (`BASE_L3`, `lval_l3`) second. The second PLL is processed even when the first fails.
- R9: When both PLLs have been attempted, `busy` falls and `done` rises and holds. `pll_err[0]` reports the CPU PLL and `pll_err[1]` the cache PLL. A new start clears `done` and both flags.
- R10: A start pulse while `busy` is 1 has no effect. The program is not restarted and no extra bus operations are issued.
- R11: Once `bus_req` is raised, it stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until a cycle with `bus_ack` high. Each acknowledged cycle completes one operation, and read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the bring-up program |
| lval_cpu | input | 32 | Multiplier for the CPU cluster PLL |
| lval_l3 | input | 32 | Multiplier for the cache PLL |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_req | output | 1 | Bus operation pending |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Operation complete |
| busy | output | 1 | Program running |
| done | output | 1 | Program finished, held until next start |
| pll_err | output | 2 | Lock timeout per PLL |

## Verification
Most internal faults show up on the bus within a handful of cycles. A wrong step index or opcode corrupts the address or data of the very next write. A lost read-modify-write merge clears bits preloaded in the bench's register model. Timer faults show up later, as tick stamps of bus writes that fall outside the 5-tick reset pause or the 100-tick lock window. A PLL-selection or error-latch fault appears only at `done`, through the base address of the second group of writes and the flag pattern.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int DW = 32;

    // Byte offsets inside one PLL bank
    localparam logic [7:0] OFS_MODE   = 8'h00;
    localparam logic [7:0] OFS_MULT   = 8'h04;
    localparam logic [7:0] OFS_CFG_LO = 8'h10;
    localparam logic [7:0] OFS_CFG_HI = 8'h14;
    localparam logic [7:0] OFS_CFG_U1 = 8'h18;
    localparam logic [7:0] OFS_OPMODE = 8'h28;
    localparam logic [7:0] OFS_MUX    = 8'h88;

    localparam int MODE_LOCK_BIT = 31;

    // Loop filter settings merged into the configuration words
    localparam logic [DW-1:0] CFG_LO_BITS = (32'd2 << 2) | (32'd2 << 4) | (32'd5 << 7)
                                          | (32'd2 << 10) | (32'd2 << 28);
    localparam logic [DW-1:0] CFG_HI_BITS = (32'd2 << 0) | (32'd1 << 4) | (32'd15 << 6);

    localparam logic [DW-1:0] SRC_FIELD = 32'h3;
    localparam logic [DW-1:0] SRC_EARLY = 32'h2;

    typedef enum logic [1:0] {
        OP_WRITE,   // plain write
        OP_MODIFY,  // read, clear, set, write back
        OP_WAIT,    // pause for the reset release interval
        OP_POLL     // repeat reads of mode until locked or timed out
    } op_kind_e;

    typedef struct packed {
        op_kind_e        kind;
        logic [7:0]      ofs;
        logic            use_mult;
        logic [DW-1:0]   clr;
        logic [DW-1:0]   set;
    } step_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_READ,
        ST_WRITE,
        ST_WAIT,
        ST_POLL
    } seq_state_e;

    localparam int NUM_STEPS = 13;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    function automatic step_t mk(op_kind_e k, logic [7:0] o, logic m,
                                 logic [DW-1:0] c, logic [DW-1:0] s);
        step_t t;
        t.kind     = k;
        t.ofs      = o;
        t.use_mult = m;
        t.clr      = c;
        t.set      = s;
        return t;
    endfunction

    // The per-PLL program; steps 11 and 12 only run after lock
    function automatic step_t step_rom(logic [STEP_W-1:0] idx);
        case (idx)
            4'd0:    return mk(OP_WRITE,  OFS_CFG_LO, 1'b0, '0, '0);
            4'd1:    return mk(OP_MODIFY, OFS_CFG_LO, 1'b0, '0, CFG_LO_BITS);
            4'd2:    return mk(OP_WRITE,  OFS_CFG_HI, 1'b0, '0, '0);
            4'd3:    return mk(OP_MODIFY, OFS_CFG_HI, 1'b0, '0, CFG_HI_BITS);
            4'd4:    return mk(OP_WRITE,  OFS_CFG_U1, 1'b0, '0, '0);
            4'd5:    return mk(OP_WRITE,  OFS_MULT,   1'b1, '0, '0);
            4'd6:    return mk(OP_MODIFY, OFS_MODE,   1'b0, '0, 32'h2);
            4'd7:    return mk(OP_WAIT,   OFS_MODE,   1'b0, '0, '0);
            4'd8:    return mk(OP_MODIFY, OFS_MODE,   1'b0, '0, 32'h4);
            4'd9:    return mk(OP_MODIFY, OFS_OPMODE, 1'b0, '0, 32'h1);
            4'd10:   return mk(OP_POLL,   OFS_MODE,   1'b0, '0, '0);
            4'd11:   return mk(OP_MODIFY, OFS_MODE,   1'b0, '0, 32'h1);
            default: return mk(OP_MODIFY, OFS_MUX,    1'b0, SRC_FIELD, SRC_EARLY);
        endcase
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Saturating count of tick pulses since the last clear
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pll_seq_bus.sv
module pll_seq_bus #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic          issue_we,
    input  logic [DW-1:0] issue_addr,
    input  logic [DW-1:0] issue_data,
    input  logic          bus_ack,
    output logic          bus_req,
    output logic          bus_we,
    output logic [DW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          op_done
);
    assign op_done = bus_req & bus_ack;

    // A new issue may coincide with the completion of the previous one
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (issue) begin
            bus_req   <= 1'b1;
            bus_we    <= issue_we;
            bus_addr  <= issue_addr;
            bus_wdata <= issue_data;
        end else if (op_done) begin
            bus_req   <= 1'b0;
        end
    end
endmodule

// File: rtl/pll_boot_seq.sv
module pll_boot_seq
    import pll_seq_pkg::*;
#(
    parameter logic [31:0] BASE_CPU     = 32'h1828_0000,
    parameter logic [31:0] BASE_L3      = 32'h1828_4000,
    parameter int          RST_WAIT_US  = 5,
    parameter int          LOCK_WAIT_US = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] lval_cpu,
    input  logic [31:0] lval_l3,
    input  logic        us_tick,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack,
    output logic        busy,
    output logic        done,
    output logic [1:0]  pll_err
);
    localparam int NUM_PLL = 2;
    localparam int MAX_US  = (LOCK_WAIT_US > RST_WAIT_US) ? LOCK_WAIT_US : RST_WAIT_US;
    localparam int CNT_W   = $clog2(MAX_US + 1) + 1;
    localparam logic [CNT_W-1:0]  WAIT_LIM  = CNT_W'(RST_WAIT_US);
    localparam logic [CNT_W-1:0]  LOCK_LIM  = CNT_W'(LOCK_WAIT_US);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    seq_state_e        state;
    logic [STEP_W-1:0] step_idx;
    logic              pll_sel;
    logic [NUM_PLL-1:0] err_q;
    logic              done_q;

    step_t             cur;
    logic [DW-1:0]     base, mult;
    logic              issue, issue_we;
    logic [DW-1:0]     issue_addr, issue_data;
    logic              op_done;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              locked_rd, advance, fail;

    assign cur       = step_rom(step_idx);
    assign base      = pll_sel ? BASE_L3 : BASE_CPU;
    assign mult      = pll_sel ? lval_l3 : lval_cpu;
    assign locked_rd = bus_rdata[MODE_LOCK_BIT];

    pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (state == ST_EXEC),
        .tick  (us_tick),
        .count (tmr_cnt)
    );

    pll_seq_bus #(.DW(DW)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .issue_we   (issue_we),
        .issue_addr (issue_addr),
        .issue_data (issue_data),
        .bus_ack    (bus_ack),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .op_done    (op_done)
    );

    // Bus requests for the current step
    always_comb begin
        issue      = 1'b0;
        issue_we   = 1'b0;
        issue_addr = base + {24'b0, cur.ofs};
        issue_data = cur.use_mult ? mult : cur.set;
        case (state)
            ST_EXEC: begin
                issue    = (cur.kind != OP_WAIT);
                issue_we = (cur.kind == OP_WRITE);
            end
            ST_READ: begin
                issue      = op_done;
                issue_we   = 1'b1;
                issue_data = (bus_rdata & ~cur.clr) | cur.set;
            end
            ST_POLL: begin
                issue = op_done && !locked_rd && (tmr_cnt < LOCK_LIM);
            end
            default: ;
        endcase
    end

    always_comb begin
        advance = ((state == ST_WRITE) && op_done)
               || ((state == ST_WAIT)  && (tmr_cnt >= WAIT_LIM))
               || ((state == ST_POLL)  && op_done && locked_rd);
        fail    = (state == ST_POLL) && op_done && !locked_rd && (tmr_cnt >= LOCK_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_idx <= '0;
            pll_sel  <= 1'b0;
            err_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_EXEC;
                    step_idx <= '0;
                    pll_sel  <= 1'b0;
                    err_q    <= '0;
                    done_q   <= 1'b0;
                end
                ST_EXEC: begin
                    case (cur.kind)
                        OP_WRITE:  state <= ST_WRITE;
                        OP_MODIFY: state <= ST_READ;
                        OP_WAIT:   state <= ST_WAIT;
                        default:   state <= ST_POLL;
                    endcase
                end
                ST_READ: if (op_done) state <= ST_WRITE;
                default: ;
            endcase

            if (advance || fail) begin
                if (fail) err_q[pll_sel] <= 1'b1;
                if (fail || step_idx == LAST_STEP) begin
                    if (pll_sel) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        pll_sel  <= 1'b1;
                        step_idx <= '0;
                        state    <= ST_EXEC;
                    end
                end else begin
                    step_idx <= step_idx + 1'b1;
                    state    <= ST_EXEC;
                end
            end
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign pll_err = err_q;

endmodule

// File: rtl/pll_seq_checks.sv
module pll_seq_checks #(
    parameter logic [31:0] BASE_CPU = 32'h1828_0000,
    parameter logic [31:0] BASE_L3  = 32'h1828_4000
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        bus_req,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        busy,
    input logic        done,
    input logic [1:0]  pll_err
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req);

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_mux_source_R6: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (bus_addr == BASE_CPU + 32'h88 || bus_addr == BASE_L3 + 32'h88)
        |-> bus_wdata[1:0] == 2'd2);

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> busy || $stable(pll_err));
endmodule

bind pll_boot_seq pll_seq_checks #(.BASE_CPU(BASE_CPU), .BASE_L3(BASE_L3)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .done      (done),
    .pll_err   (pll_err)
);

// File: tb/pll_boot_seq_test.sv
`timescale 1ns/1ps
module pll_boot_seq_test;
    localparam logic [31:0] B0 = 32'h1828_0000;
    localparam logic [31:0] B1 = 32'h1828_4000;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, us_tick = 1'b0;
    logic [31:0] lval_cpu = 32'h4F, lval_l3 = 32'h3F;
    logic bus_req, bus_we, bus_ack = 1'b0, busy, done;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [1:0] pll_err;

    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    pll_boot_seq uut (
        .clk(clk), .rst(rst), .start(start), .lval_cpu(lval_cpu), .lval_l3(lval_l3),
        .us_tick(us_tick), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .pll_err(pll_err));

    // ---------------- register bank and lock model ----------------
    logic [31:0] bank [2][64];
    int lock_after [2];
    int rstn_tick [2];
    bit rstn_seen [2];
    int tick_cnt = 0;
    logic [31:0] wl_addr [64];
    logic [31:0] wl_data [64];
    int wl_tick [64];
    int wl_n = 0;
    int hs_err = 0;
    bit prev_pend = 0;
    logic [31:0] prev_addr, prev_data;
    logic prev_we;

    function automatic bit is_locked(int p);
        return rstn_seen[p] && lock_after[p] >= 0 && (tick_cnt - rstn_tick[p]) >= lock_after[p];
    endfunction

    always @(posedge clk) begin
        if (us_tick) tick_cnt++;
        if (prev_pend && (!bus_req || bus_addr != prev_addr || bus_we != prev_we || bus_wdata != prev_data))
            hs_err++;
        prev_pend = bus_req && !bus_ack;
        prev_addr = bus_addr; prev_data = bus_wdata; prev_we = bus_we;
        if (rst) begin
            bus_ack <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            int p;
            int w;
            p = (bus_addr >= B1) ? 1 : 0;
            w = int'((bus_addr - (p == 1 ? B1 : B0)) >> 2) & 63;
            bus_ack <= 1'b1;
            if (bus_we) begin
                bank[p][w] = bus_wdata;
                if (wl_n < 64) begin
                    wl_addr[wl_n] = bus_addr; wl_data[wl_n] = bus_wdata; wl_tick[wl_n] = tick_cnt;
                    wl_n++;
                end
                if (w == 0 && bus_wdata[2] && !rstn_seen[p]) begin
                    rstn_seen[p] = 1'b1; rstn_tick[p] = tick_cnt;
                end
            end else begin
                bus_rdata <= bank[p][w] | ((w == 0 && is_locked(p)) ? 32'h8000_0000 : 32'h0);
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            us_tick = (div == 9);
            div = (div == 9) ? 0 : div + 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic prep(int l0, int l1);
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 64; i++) bank[p][i] = '0;
            bank[p][0]  = 32'h20;      // unrelated mode bit
            bank[p][4]  = 32'h5;       // stale config, must be cleared
            bank[p][10] = 32'h10;      // unrelated opmode bit
            bank[p][34] = 32'hF0F1;    // mux with source 1
            rstn_seen[p] = 1'b0;
        end
        lock_after[0] = l0; lock_after[1] = l1;
        wl_n = 0;
    endtask

    task automatic pulse_start;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Check one PLL's write group starting at log index s; return next index
    task automatic chk_pll(int p, int s, logic [31:0] mult, bit lock, output int nxt);
        logic [31:0] b, ea [11], ed [11];
        int n;
        b = (p == 1) ? B1 : B0;
        ea = '{32'h10, 32'h10, 32'h14, 32'h14, 32'h18, 32'h04, 32'h00, 32'h00, 32'h28, 32'h00, 32'h88};
        ed = '{32'h0, 32'h20000AA8, 32'h0, 32'h3D2, 32'h0, mult, 32'h22, 32'h26, 32'h11,
               32'h8000_0027, 32'hF0F2};
        n = lock ? 11 : 9;
        for (int i = 0; i < n; i++) begin
            chk(wl_addr[s+i] == b + ea[i], "R2/R8", $sformatf("pll%0d write %0d addr", p, i),
                wl_addr[s+i], b + ea[i]);
            chk(wl_data[s+i] == ed[i], (i >= 6) ? "R3/R6" : "R2", $sformatf("pll%0d write %0d data", p, i),
                wl_data[s+i], ed[i]);
        end
        chk(wl_tick[s+7] - wl_tick[s+6] >= 5, "R4", "ticks between bypass and reset release",
            32'(wl_tick[s+7] - wl_tick[s+6]), 32'd5);
        chk(bank[p][0][5] && bank[p][10][4], "R3", "unrelated mode/opmode bits kept",
            {bank[p][0][5], bank[p][10][4]}, 32'd3);
        if (!lock)
            chk(bank[p][34] == 32'hF0F1, "R7", "mux untouched after timeout", bank[p][34], 32'hF0F1);
        nxt = s + n;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(!busy && !done && !bus_req && pll_err == 2'b00, "R1", "reset outputs",
            {busy, done, bus_req, pll_err}, 32'h0);
    endtask

    task automatic t_both_lock;
        int k;
        prep(3, 3);
        pulse_start;
        wait_done;
        chk_pll(0, 0, 32'h4F, 1'b1, k);
        chk_pll(1, k, 32'h3F, 1'b1, k);
        chk(wl_n == 22, "R5", "write count both locked", wl_n, 22);
        chk(pll_err == 2'b00 && !busy && !bus_req, "R9", "flags after success", pll_err, 0);
    endtask

    task automatic t_first_timeout;
        int k;
        prep(-1, 3);
        lval_cpu = 32'h1234_5678; lval_l3 = 32'h0000_0A0B;
        pulse_start;
        wait_done;
        chk_pll(0, 0, 32'h1234_5678, 1'b0, k);
        chk(wl_tick[9] - wl_tick[8] >= 100 && wl_tick[9] - wl_tick[8] <= 102, "R7",
            "lock window length", 32'(wl_tick[9] - wl_tick[8]), 32'd100);
        chk_pll(1, k, 32'h0000_0A0B, 1'b1, k);
        chk(pll_err == 2'b01 && done, "R8", "second pll served after first fails", pll_err, 2'b01);
        lval_cpu = 32'h4F; lval_l3 = 32'h3F;
    endtask

    task automatic t_both_timeout;
        int k;
        prep(-1, -1);
        pulse_start;
        wait_done;
        chk_pll(0, 0, 32'h4F, 1'b0, k);
        chk_pll(1, k, 32'h3F, 1'b0, k);
        chk(pll_err == 2'b11 && wl_n == 18, "R7", "both timed out", {wl_n[7:0], 6'd0, pll_err}, 32'h1203);
    endtask

    task automatic t_late_lock;
        prep(95, 90);
        pulse_start;
        wait_done;
        chk(pll_err == 2'b00 && wl_n == 22, "R5", "lock near window end", pll_err, 0);
    endtask

    task automatic t_start_busy;
        prep(3, 3);
        pulse_start;
        chk(busy && !done && pll_err == 2'b00, "R9", "new start clears done and flags",
            {busy, done, pll_err}, 32'h8);
        repeat (40) @(negedge clk);
        pulse_start;
        repeat (20) @(negedge clk);
        pulse_start;
        wait_done;
        chk(wl_n == 22 && wl_addr[0] == B0 + 32'h10 && wl_addr[11] == B1 + 32'h10, "R10",
            "start while busy ignored", wl_n, 22);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_both_lock;
        t_first_timeout;
        t_start_busy;
        t_both_timeout;
        t_late_lock;
        chk(hs_err == 0, "R11", "request held until acknowledged", hs_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule